// File: doc/BRIEF.md
# Flash Sector Protection Command Decoder

This block observes the command bus of a flash memory and recognises the short, unlock-prefixed write sequences that manage sector protection. It keeps one volatile protect bit per sector (the dynamic bits), one persistent protect bit per sector, a global freeze bit that blocks changes to the persistent bits, and two mode-selection bits, one for password-guarded protection and one for persistent protection. A sequence that ends in a read cycle returns a status word on the read data port. No other read data is produced: array reads in idle mode return zero.

Each bus cycle is one clock with `we` or `re` high. Between cycles the machine holds its state. The sequencer walks through these states: `S_IDLE`, then `S_UNL1` after the first unlock write, then `S_UNL2` after the second. From `S_UNL2`, the opcode selects one of the following:
- `S_DYB_WR`: await the dynamic-bit write.
- `S_ST_DYB`: await the dynamic/freeze status read.
- `S_ST_PPB`: await the persistent status read.
- `S_PRE60`: the setup step for persistent and mode commands.
- Back to `S_IDLE`: the freeze-bit set command, or any unknown opcode.

From `S_PRE60`, a program opcode leads to `S_PRG` and an erase opcode leads to `S_ERA`. Both of these confirm into `S_RESULT`, whose read cycle returns the outcome. Every terminal cycle, every mismatching cycle and every `cmd_rst` returns the machine to `S_IDLE`.

Top module: `prot_cmd_decoder`

## Requirements
- R1: A sequence starts with a write of AAh to address 555h, then a write of 55h to address 2AAh. Only address bits 11..0 and data bits 7..0 are compared. Bits 21..12 of the address and bits 15..8 of the data are ignored.
- R2: A write whose address or data does not fit the current step returns the machine to idle. A read in any state that does not expect one does the same. A read in idle returns 0000h.
- R3: After the prefix, a write of 48h to 555h followed by any write sets the dynamic bit of the addressed sector if data bit 0 is 1, and clears it if data bit 0 is 0.
- R4: After the prefix, a write of 58h to 555h followed by a read returns the addressed sector's dynamic bit on bit 0 and the freeze bit on bit 1. All other bits read 0.
- R5: After the prefix, a write of 90h to 555h followed by a read at an address whose low byte is 02h returns that sector's persistent bit on bit 0.
- R6: Persistent program uses three writes after the prefix: 60h to 555h, then 68h at a sector address with low byte 02h, then 48h at exactly that address. The sector's persistent bit is then set, and the following read returns 0001h.
- R7: Erase-all uses the same shape with the opcodes 60h, 60h and 40h, where the last two writes use low byte 02h. It clears every persistent bit, and the following read returns 0001h.
- R8: A write of 78h to 555h after the prefix sets the freeze bit. While the freeze bit is set, persistent program and erase change nothing, and their final read returns 0000h.
- R9: The program shape with low byte 0Ah sets the password-mode bit, and with low byte 12h it sets the persistent-mode bit. In both cases the final read returns 0001h. After 60h to 555h, a read at low byte 0Ah or 12h returns the corresponding bit on bit 0.
- R10: `cmd_rst` returns the machine to idle and clears the dynamic bits and the freeze bit. It keeps the persistent and mode bits. A write in the same cycle as `cmd_rst` has no effect.
- R11: `rst_n` low clears all protection state, including the persistent and mode bits.
- R12: Address bits 21..12 select one of 1024 sectors. A command on one sector leaves every other sector's bits unchanged.
- R13: A cycle with `we` and `re` both high is a write, and `rdata` reads 0000h during it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, clears all state |
| cmd_rst | input | 1 | Synchronous command reset, keeps persistent and mode bits |
| we | input | 1 | Write cycle strobe |
| re | input | 1 | Read cycle strobe |
| addr | input | 22 | Word address of the current cycle |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for status and result cycles |

## Verification
Two events can land in the same clock: a `cmd_rst` pulse, and the terminal write of a dynamic-bit sequence. The bench raises `cmd_rst` together with the final write to one sector. A later status read of that sector must show the bit still clear, which confirms that the reset took priority and the write was dropped. A second overlap drives `we` and `re` together during a pending status read. There, `rdata` must stay at zero in that cycle and the sequence must be abandoned.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UNL1,
        S_UNL2,
        S_DYB_WR,
        S_ST_DYB,
        S_ST_PPB,
        S_PRE60,
        S_PRG,
        S_ERA,
        S_RESULT
    } seq_state_t;

    localparam logic [11:0] ADR_KEY1 = 12'h555;
    localparam logic [11:0] ADR_KEY2 = 12'h2AA;

    localparam logic [7:0] OP_KEY1  = 8'hAA;
    localparam logic [7:0] OP_KEY2  = 8'h55;
    localparam logic [7:0] OP_DYB   = 8'h48;
    localparam logic [7:0] OP_STAT  = 8'h58;
    localparam logic [7:0] OP_PSTAT = 8'h90;
    localparam logic [7:0] OP_SETUP = 8'h60;
    localparam logic [7:0] OP_PROG  = 8'h68;
    localparam logic [7:0] OP_CONF  = 8'h48;
    localparam logic [7:0] OP_ERASE = 8'h40;
    localparam logic [7:0] OP_FRZ   = 8'h78;

    localparam logic [7:0] LB_SECT = 8'h02;
    localparam logic [7:0] LB_PWM  = 8'h0A;
    localparam logic [7:0] LB_PSM  = 8'h12;

endpackage

// File: rtl/prot_bit_array.sv
module prot_bit_array #(
    parameter int SECT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    input  logic              wr_en,
    input  logic [SECT_W-1:0] idx,
    input  logic              wr_val,
    input  logic              clr_all,
    output logic              rd_bit
);
    localparam int NSECT = 1 << SECT_W;

    logic [NSECT-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (sync_clr || clr_all) begin
            bits_q <= '0;
        end else if (wr_en) begin
            bits_q[idx] <= wr_val;
        end
    end

    assign rd_bit = bits_q[idx];

    // R12: with no write and no clear, no bit of the array moves
    a_r12_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr_all && !sync_clr) |=> $stable(bits_q));

    // R12: a write touches at most the addressed bit
    a_r12_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all && !sync_clr) |=> ($countones(bits_q ^ $past(bits_q)) <= 1));

endmodule

// File: rtl/prot_seq_fsm.sv
module prot_seq_fsm
    import prot_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_rst,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              dyb_bit,
    input  logic              ppb_bit,
    input  logic              frz_q,
    input  logic              pwm_q,
    input  logic              psm_q,
    output logic              dyb_wr,
    output logic              dyb_val,
    output logic              ppb_set,
    output logic              ppb_clr_all,
    output logic              frz_set,
    output logic              pwm_set,
    output logic              psm_set,
    output logic [DATA_W-1:0] rdata
);
    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] hold_q, hold_d;
    logic              res_q, res_d;

    logic        wr, rd, cyc, confirm;
    logic [11:0] lo12;
    logic [7:0]  lb, op;

    assign wr      = we;
    assign rd      = re && !we;
    assign cyc     = we || re;
    assign lo12    = addr[11:0];
    assign lb      = addr[7:0];
    assign op      = wdata[7:0];
    assign confirm = wr && (op == OP_CONF) && (addr == hold_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            hold_q  <= '0;
            res_q   <= 1'b0;
        end else if (cmd_rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
            res_q   <= res_d;
        end
    end

    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        res_d   = res_q;
        unique case (state_q)
            S_IDLE: begin
                if (wr && op == OP_KEY1 && lo12 == ADR_KEY1) state_d = S_UNL1;
            end
            S_UNL1: begin
                if (wr && op == OP_KEY2 && lo12 == ADR_KEY2) state_d = S_UNL2;
                else if (cyc)                                state_d = S_IDLE;
            end
            S_UNL2: begin
                if (wr && lo12 == ADR_KEY1) begin
                    case (op)
                        OP_DYB:   state_d = S_DYB_WR;
                        OP_STAT:  state_d = S_ST_DYB;
                        OP_PSTAT: state_d = S_ST_PPB;
                        OP_SETUP: state_d = S_PRE60;
                        default:  state_d = S_IDLE;
                    endcase
                end else if (cyc) begin
                    state_d = S_IDLE;
                end
            end
            S_PRE60: begin
                if (wr && op == OP_PROG && (lb == LB_SECT || lb == LB_PWM || lb == LB_PSM)) begin
                    state_d = S_PRG;
                    hold_d  = addr;
                end else if (wr && op == OP_SETUP && lb == LB_SECT) begin
                    state_d = S_ERA;
                end else if (cyc) begin
                    state_d = S_IDLE;
                end
            end
            S_PRG: begin
                if (confirm) begin
                    state_d = S_RESULT;
                    res_d   = (hold_q[7:0] == LB_SECT) ? !frz_q : 1'b1;
                end else if (cyc) begin
                    state_d = S_IDLE;
                end
            end
            S_ERA: begin
                if (wr && op == OP_ERASE && lb == LB_SECT) begin
                    state_d = S_RESULT;
                    res_d   = !frz_q;
                end else if (cyc) begin
                    state_d = S_IDLE;
                end
            end
            S_DYB_WR, S_ST_DYB, S_ST_PPB, S_RESULT: begin
                if (cyc) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        dyb_wr      = 1'b0;
        dyb_val     = wdata[0];
        ppb_set     = 1'b0;
        ppb_clr_all = 1'b0;
        frz_set     = 1'b0;
        pwm_set     = 1'b0;
        psm_set     = 1'b0;
        rdata       = '0;
        unique case (state_q)
            S_UNL2:   frz_set = wr && lo12 == ADR_KEY1 && op == OP_FRZ;
            S_DYB_WR: dyb_wr  = wr;
            S_PRG: begin
                if (confirm) begin
                    case (hold_q[7:0])
                        LB_SECT: ppb_set = !frz_q;
                        LB_PWM:  pwm_set = 1'b1;
                        LB_PSM:  psm_set = 1'b1;
                        default: ;
                    endcase
                end
            end
            S_ERA:    ppb_clr_all = wr && op == OP_ERASE && lb == LB_SECT && !frz_q;
            S_ST_DYB: if (rd) rdata[1:0] = {frz_q, dyb_bit};
            S_ST_PPB: if (rd && lb == LB_SECT) rdata[0] = ppb_bit;
            S_PRE60: begin
                if (rd && lb == LB_PWM)      rdata[0] = pwm_q;
                else if (rd && lb == LB_PSM) rdata[0] = psm_q;
            end
            S_RESULT: if (rd) rdata[0] = res_q;
            default: ;
        endcase
        if (cmd_rst) begin
            dyb_wr      = 1'b0;
            ppb_set     = 1'b0;
            ppb_clr_all = 1'b0;
            frz_set     = 1'b0;
            pwm_set     = 1'b0;
            psm_set     = 1'b0;
        end
    end

    // R10: command reset always lands in idle
    a_r10_reset_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst |=> state_q == S_IDLE);

    // R2: idle reads return zero
    a_r2_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && re) |-> rdata == '0);

    // R13: a write cycle never drives read data
    a_r13_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> rdata == '0);

    // R8: frozen persistent bits receive no program or erase
    a_r8_frozen_block: assert property (@(posedge clk) disable iff (!rst_n)
        frz_q |-> (!ppb_set && !ppb_clr_all));

    // R3: at most one state change is requested per cycle
    a_r3_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dyb_wr, ppb_set, ppb_clr_all, frz_set, pwm_set, psm_set}));

endmodule

// File: rtl/prot_cmd_decoder.sv
module prot_cmd_decoder #(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_rst,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int SECT_W = ADDR_W - SECT_LSB;

    logic [SECT_W-1:0] sect;
    logic dyb_bit, ppb_bit;
    logic dyb_wr, dyb_val, ppb_set, ppb_clr_all, frz_set, pwm_set, psm_set;
    logic frz_q, pwm_q, psm_q;

    assign sect = addr[ADDR_W-1:SECT_LSB];

    prot_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_rst(cmd_rst),
        .we(we), .re(re), .addr(addr), .wdata(wdata),
        .dyb_bit(dyb_bit), .ppb_bit(ppb_bit),
        .frz_q(frz_q), .pwm_q(pwm_q), .psm_q(psm_q),
        .dyb_wr(dyb_wr), .dyb_val(dyb_val),
        .ppb_set(ppb_set), .ppb_clr_all(ppb_clr_all),
        .frz_set(frz_set), .pwm_set(pwm_set), .psm_set(psm_set),
        .rdata(rdata)
    );

    prot_bit_array #(.SECT_W(SECT_W)) u_dyb (
        .clk(clk), .rst_n(rst_n), .sync_clr(cmd_rst),
        .wr_en(dyb_wr), .idx(sect), .wr_val(dyb_val),
        .clr_all(1'b0), .rd_bit(dyb_bit)
    );

    prot_bit_array #(.SECT_W(SECT_W)) u_ppb (
        .clk(clk), .rst_n(rst_n), .sync_clr(1'b0),
        .wr_en(ppb_set), .idx(sect), .wr_val(1'b1),
        .clr_all(ppb_clr_all), .rd_bit(ppb_bit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frz_q <= 1'b0;
            pwm_q <= 1'b0;
            psm_q <= 1'b0;
        end else begin
            if (cmd_rst)      frz_q <= 1'b0;
            else if (frz_set) frz_q <= 1'b1;
            if (pwm_set) pwm_q <= 1'b1;
            if (psm_set) psm_q <= 1'b1;
        end
    end

    // R10: the freeze bit only falls on command reset
    a_r10_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_q && !cmd_rst) |=> frz_q);

    // R10: mode bits survive command reset
    a_r10_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst |=> (pwm_q == $past(pwm_q) && psm_q == $past(psm_q)));

endmodule

// File: tb/prot_cmd_decoder_tb.sv
module prot_cmd_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_rst = 1'b0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [21:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prot_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_rst(cmd_rst),
        .we(we), .re(re), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [21:0] sa(input int sec, input logic [7:0] lb);
        sa = {sec[9:0], 4'h0, lb};
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [21:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 we = 1'b0;
    endtask

    task automatic bus_rd(input logic [21:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        re = 1'b1; addr = a;
        #1 check(rdata, exp, req);
        @(posedge clk);
        #1 re = 1'b0;
    endtask

    task automatic unlock();
        bus_wr(22'h000555, 16'h00AA);
        bus_wr(22'h0002AA, 16'h0055);
    endtask

    task automatic dyb_write(input int sec, input logic [15:0] d);
        unlock();
        bus_wr(22'h000555, 16'h0048);
        bus_wr(sa(sec, 8'h00), d);
    endtask

    task automatic dyb_status(input int sec, input logic [15:0] exp, input string req);
        unlock();
        bus_wr(22'h000555, 16'h0058);
        bus_rd(sa(sec, 8'h00), exp, req);
    endtask

    task automatic ppb_status(input int sec, input logic [15:0] exp, input string req);
        unlock();
        bus_wr(22'h000555, 16'h0090);
        bus_rd(sa(sec, 8'h02), exp, req);
    endtask

    task automatic prog_seq(input logic [21:0] a, input logic [15:0] exp, input string req);
        unlock();
        bus_wr(22'h000555, 16'h0060);
        bus_wr(a, 16'h0068);
        bus_wr(a, 16'h0048);
        bus_rd(22'h0, exp, req);
    endtask

    task automatic erase_seq(input logic [15:0] exp, input string req);
        unlock();
        bus_wr(22'h000555, 16'h0060);
        bus_wr(22'h000002, 16'h0060);
        bus_wr(22'h000002, 16'h0040);
        bus_rd(22'h0, exp, req);
    endtask

    task automatic mode_read(input logic [7:0] lb, input logic [15:0] exp, input string req);
        unlock();
        bus_wr(22'h000555, 16'h0060);
        bus_rd({14'h0, lb}, exp, req);
    endtask

    task automatic t_reset_state();
        bus_rd(22'h000123, 16'h0000, "R11 idle read after reset");
        dyb_status(0, 16'h0000, "R11 dynamic bit after reset");
        ppb_status(0, 16'h0000, "R11 persistent bit after reset");
    endtask

    task automatic t_dynamic();
        // R1: upper address and data bits ignored on prefix cycles
        bus_wr(22'h3FF555, 16'hC3AA);
        bus_wr(22'h2AA2AA, 16'h7E55);
        bus_wr(22'h000555, 16'hFF48);
        bus_wr(sa(5, 8'h00), 16'hFF01);
        dyb_status(5, 16'h0001, "R1 R3 R4 dynamic set sector 5");
        dyb_status(6, 16'h0000, "R12 neighbour sector 6 untouched");
        dyb_write(5, 16'h0100);
        dyb_status(5, 16'h0000, "R3 dynamic clear via bit 0");
    endtask

    task automatic t_abort();
        bus_wr(22'h000555, 16'h00AA);
        bus_wr(22'h0002AB, 16'h0055);
        bus_wr(22'h000555, 16'h0048);
        bus_wr(sa(5, 8'h00), 16'h0001);
        bus_rd(sa(5, 8'h00), 16'h0000, "R2 read after aborted prefix");
        dyb_status(5, 16'h0000, "R2 aborted sequence wrote nothing");
        unlock();
        bus_rd(22'h000555, 16'h0000, "R2 read in prefix state returns zero");
        bus_wr(22'h000555, 16'h0058);
        dyb_status(5, 16'h0000, "R2 status after abort by read");
    endtask

    task automatic t_persistent();
        prog_seq(sa(7, 8'h02), 16'h0001, "R6 program result");
        ppb_status(7, 16'h0001, "R5 R6 persistent bit sector 7");
        ppb_status(8, 16'h0000, "R12 persistent bit sector 8 clear");
        prog_seq(sa(9, 8'h02), 16'h0001, "R6 program sector 9");
        erase_seq(16'h0001, "R7 erase result");
        ppb_status(7, 16'h0000, "R7 sector 7 erased");
        ppb_status(9, 16'h0000, "R7 sector 9 erased");
    endtask

    task automatic t_modes();
        prog_seq(22'h00000A, 16'h0001, "R9 password mode program result");
        mode_read(8'h0A, 16'h0001, "R9 password mode bit set");
        mode_read(8'h12, 16'h0000, "R9 persistent mode bit clear");
        prog_seq(22'h000012, 16'h0001, "R9 persistent mode program result");
        mode_read(8'h12, 16'h0001, "R9 persistent mode bit set");
    endtask

    task automatic t_freeze();
        prog_seq(sa(3, 8'h02), 16'h0001, "R6 program sector 3");
        unlock();
        bus_wr(22'h000555, 16'h0078);
        dyb_status(3, 16'h0002, "R8 R4 freeze bit on bit 1");
        prog_seq(sa(4, 8'h02), 16'h0000, "R8 frozen program result");
        ppb_status(4, 16'h0000, "R8 frozen program ignored");
        erase_seq(16'h0000, "R8 frozen erase result");
        ppb_status(3, 16'h0001, "R8 frozen erase ignored");
    endtask

    task automatic t_cmd_reset();
        dyb_write(10, 16'h0001);
        dyb_status(10, 16'h0002 | 16'h0001, "R3 sector 10 set before reset");
        @(negedge clk);
        cmd_rst = 1'b1;
        @(posedge clk);
        #1 cmd_rst = 1'b0;
        dyb_status(10, 16'h0000, "R10 dynamic and freeze cleared");
        ppb_status(3, 16'h0001, "R10 persistent bit kept");
        mode_read(8'h0A, 16'h0001, "R10 mode bit kept");
        // R10: reset in the same cycle as the terminal write
        unlock();
        bus_wr(22'h000555, 16'h0048);
        @(negedge clk);
        we = 1'b1; addr = sa(11, 8'h00); wdata = 16'h0001; cmd_rst = 1'b1;
        @(posedge clk);
        #1 begin we = 1'b0; cmd_rst = 1'b0; end
        dyb_status(11, 16'h0000, "R10 coinciding write dropped");
    endtask

    task automatic t_both_strobes();
        dyb_write(12, 16'h0001);
        unlock();
        bus_wr(22'h000555, 16'h0058);
        @(negedge clk);
        we = 1'b1; re = 1'b1; addr = sa(12, 8'h00); wdata = 16'h0000;
        #1 check(rdata, 16'h0000, "R13 write and read together reads zero");
        @(posedge clk);
        #1 begin we = 1'b0; re = 1'b0; end
        bus_rd(sa(12, 8'h00), 16'h0000, "R13 sequence abandoned");
        dyb_status(12, 16'h0001, "R13 dynamic bit unchanged");
    endtask

    task automatic t_por();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        ppb_status(3, 16'h0000, "R11 persistent cleared by power-on reset");
        mode_read(8'h0A, 16'h0000, "R11 mode bit cleared by power-on reset");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset_state();
        t_dynamic();
        t_abort();
        t_persistent();
        t_modes();
        t_freeze();
        t_cmd_reset();
        t_both_strobes();
        t_por();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule